// File: doc/BRIEF.md
# Step Dimming Sequencer

This block holds the dimming state of a primary-side constant-current LED controller and turns it into a digital code for the output-current reference. The user dims the lamp by switching the mains off and on again. Each interruption produces a brown-out at the line-sense comparator. The block qualifies that indication with a blanking counter. It then moves the reference one level down a fixed six-level ladder: 100%, 70%, 40%, 25%, 10% and 5% of the 250 mV nominal. After the 5% level, the next event returns the ladder to full current.

The level survives the mains interruption itself and is cleared only by a supply-reset flag. That flag is raised when the controller supply falls below its reset threshold. The block also drives the enable of the line feed-forward offset source. This enable uses hysteresis on the reference code, so the source is off at the deepest dimming level and comes back on when the reference rises again.

Top module: `dimstep_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `step_idx` is 0, `ref_code` is 500 and `ofs_en` is 1.
- R2: The brown-out is qualified only after `bo_raw` has been sampled high on `BLANK_CYC` consecutive rising clock edges. A single low sample restarts the count, so a high stretch of `BLANK_CYC-1` edges has no effect on `step_idx`.
- R3: Each qualified brown-out advances `step_idx` exactly once, however long `bo_raw` stays high. Without a qualified event or supply reset, `step_idx` holds.
- R4: `ref_code` is the reference in units of 0.5 mV: step 0 gives 500, 1 gives 350, 2 gives 200, 3 gives 125, 4 gives 50 and 5 gives 25.
- R5: A qualified brown-out at step 5 returns `step_idx` to 0.
- R6: A high `supply_rst` sampled on a clock edge sets `step_idx` to 0 on that edge and discards any partial qualification count. This takes priority over an event in the same cycle.
- R7: `ofs_en` goes to 0 one edge after `ref_code` is below `OFF_CODE` (default 30, i.e. 15 mV). It goes to 1 one edge after `ref_code` is above `ON_CODE` (default 40, i.e. 20 mV). Between the two it holds.
- R8: With `bo_raw` rising before edge 1 and held, `step_idx` changes on edge `BLANK_CYC+1` and `ofs_en` can change on edge `BLANK_CYC+2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bo_raw | input | 1 | Line-sense comparator output, high while the line is below its threshold |
| supply_rst | input | 1 | Supply below reset threshold, clears the dimming state |
| ref_code | output | REF_W | Current reference in 0.5 mV units |
| step_idx | output | 3 | Dimming step, 0 = full current, 5 = deepest |
| ofs_en | output | 1 | Enable of the line feed-forward offset source |

## Verification
A corrupted step register shows at once on `step_idx` and, through the decode, on `ref_code` in the same cycle. A wrong offset-enable state is visible one edge later on `ofs_en`. A qualification counter that counts wrongly appears as a step change one or more edges early or late relative to edge `BLANK_CYC+1`. A missed reset of that counter shows as a short glitch advancing the ladder. A lost edge detector shows as several advances during one long brown-out.

// File: rtl/dimstep_pkg.sv
package dimstep_pkg;
  localparam int NUM_STEPS = 6;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int REF_W     = 10;

  typedef logic [STEP_W-1:0] step_t;

  // reference per step, 0.5 mV units (percent of 250 mV times 2)
  function automatic logic [REF_W-1:0] step_ref(input step_t s);
    logic [REF_W-1:0] r;
    case (s)
      3'd0:    r = 10'd500;
      3'd1:    r = 10'd350;
      3'd2:    r = 10'd200;
      3'd3:    r = 10'd125;
      3'd4:    r = 10'd50;
      3'd5:    r = 10'd25;
      default: r = 10'd500;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dimstep_bo_qual.sv
module dimstep_bo_qual #(
  parameter int BLANK_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic raw,
  output logic qual
);
  localparam int CNT_W = $clog2(BLANK_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             qual_q, qual_d;

  always_comb begin
    cnt_d  = cnt_q;
    qual_d = qual_q;
    if (clr || !raw) begin
      cnt_d  = '0;
      qual_d = 1'b0;
    end else if (cnt_q == LAST) begin
      qual_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      qual_q <= qual_d;
    end
  end

  assign qual = qual_q;
endmodule

// File: rtl/dimstep_ladder.sv
module dimstep_ladder
  import dimstep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  qual,
  output logic  evt,
  output step_t step
);
  localparam step_t LAST_STEP = step_t'(NUM_STEPS - 1);

  logic  qual_d1;
  step_t step_q, step_d;
  logic  step_en;

  assign evt     = qual & ~qual_d1;
  assign step_en = clr | evt;

  always_comb begin
    if (clr)                    step_d = '0;
    else if (step_q == LAST_STEP) step_d = '0;
    else                        step_d = step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_d1 <= 1'b0;
      step_q  <= '0;
    end else begin
      qual_d1 <= qual;
      if (step_en) step_q <= step_d;
    end
  end

  assign step = step_q;
endmodule

// File: rtl/dimstep_ofs_hyst.sv
module dimstep_ofs_hyst #(
  parameter int REF_W    = 10,
  parameter int OFF_CODE = 30,
  parameter int ON_CODE  = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] ref_in,
  output logic             en
);
  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (en_q && (ref_in < REF_W'(OFF_CODE)))      en_d = 1'b0;
    else if (!en_q && (ref_in > REF_W'(ON_CODE))) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_d;
  end

  assign en = en_q;
endmodule

// File: rtl/dimstep_seq.sv
module dimstep_seq
  import dimstep_pkg::*;
#(
  parameter int BLANK_CYC = 50000,
  parameter int OFF_CODE  = 30,
  parameter int ON_CODE   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bo_raw,
  input  logic             supply_rst,
  output logic [REF_W-1:0] ref_code,
  output logic [2:0]       step_idx,
  output logic             ofs_en
);
  logic  bo_q;
  logic  bo_evt;
  step_t step;

  dimstep_bo_qual #(.BLANK_CYC(BLANK_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .clr(supply_rst), .raw(bo_raw), .qual(bo_q)
  );

  dimstep_ladder u_ladder (
    .clk(clk), .rst_n(rst_n), .clr(supply_rst), .qual(bo_q),
    .evt(bo_evt), .step(step)
  );

  assign ref_code = step_ref(step);
  assign step_idx = 3'(step);

  dimstep_ofs_hyst #(.REF_W(REF_W), .OFF_CODE(OFF_CODE), .ON_CODE(ON_CODE)) u_ofs (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_code), .en(ofs_en)
  );
endmodule

// File: rtl/dimstep_seq_chk.sv
module dimstep_seq_chk #(
  parameter int REF_W    = 10,
  parameter int OFF_CODE = 30,
  parameter int ON_CODE  = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bo_raw,
  input logic             supply_rst,
  input logic             bo_q,
  input logic             bo_evt,
  input logic [REF_W-1:0] ref_code,
  input logic [2:0]       step_idx,
  input logic             ofs_en
);
  // R2
  raw_low_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bo_raw |=> !bo_q);
  // R3
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bo_evt && !supply_rst) |=> $stable(step_idx));
  // R3
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_evt && !supply_rst && step_idx < 3'd5) |=> step_idx == $past(step_idx) + 3'd1);
  // R5
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_evt && !supply_rst && step_idx == 3'd5) |=> step_idx == 3'd0);
  // R6
  supply_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_rst |=> (step_idx == 3'd0 && !bo_q));
  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_idx <= 3'd5);
  // R7
  ofs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code < REF_W'(OFF_CODE)) |=> !ofs_en);
  // R7
  ofs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code > REF_W'(ON_CODE)) |=> ofs_en);
endmodule

bind dimstep_seq dimstep_seq_chk #(.REF_W(REF_W), .OFF_CODE(OFF_CODE), .ON_CODE(ON_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bo_raw(bo_raw), .supply_rst(supply_rst),
  .bo_q(bo_q), .bo_evt(bo_evt), .ref_code(ref_code), .step_idx(step_idx),
  .ofs_en(ofs_en)
);

// File: tb/dimstep_seq_bench.sv
module dimstep_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK      = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bo_raw;
  logic       supply_rst;
  logic [9:0] ref_code;
  logic [2:0] step_idx;
  logic       ofs_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int mstep  = 0;
  bit mofs   = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dimstep_seq #(.BLANK_CYC(BLANK)) u_dimstep_seq (
    .clk(clk), .rst_n(rst_n), .bo_raw(bo_raw), .supply_rst(supply_rst),
    .ref_code(ref_code), .step_idx(step_idx), .ofs_en(ofs_en)
  );

  function automatic int exp_ref(input int s);
    int pct;
    case (s)
      0: pct = 100; 1: pct = 70; 2: pct = 40;
      3: pct = 25;  4: pct = 10; default: pct = 5;
    endcase
    return pct * 5;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " step"}, step_idx, mstep);
    chk({req, " ref"},  ref_code, exp_ref(mstep));
    chk({req, " ofs"},  ofs_en,   mofs);
  endtask

  function automatic bit next_ofs(input bit cur, input int r);
    if (cur && r < 30) return 1'b0;
    if (!cur && r > 40) return 1'b1;
    return cur;
  endfunction

  // one full qualified brown-out, then line back; model updated
  task automatic brownout(input int hold);
    bo_raw = 1'b1;
    repeat (hold) @(negedge clk);
    bo_raw = 1'b0;
    repeat (3) @(negedge clk);
    mstep = (mstep == 5) ? 0 : mstep + 1;
    mofs  = next_ofs(mofs, exp_ref(mstep));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bo_raw = 1'b0; supply_rst = 1'b0;
    repeat (3) @(negedge clk);
    mstep = 0; mofs = 1'b1;
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 after release");
  endtask

  task automatic t_short_glitch;
    bo_raw = 1'b1;
    repeat (BLANK - 1) @(negedge clk);
    bo_raw = 1'b0;
    @(negedge clk);
    bo_raw = 1'b1;
    repeat (BLANK - 1) @(negedge clk);
    bo_raw = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R2 restart on interruption");
  endtask

  task automatic t_exact_timing;
    bo_raw = 1'b1;
    repeat (BLANK) @(negedge clk);
    chk("R8 no step at edge BLANK", step_idx, mstep);
    @(negedge clk);
    chk("R8 step at edge BLANK+1", step_idx, mstep + 1);
    chk("R8 ref at edge BLANK+1", ref_code, exp_ref(mstep + 1));
    repeat (BLANK * 4) @(negedge clk);
    chk("R3 single advance on long hold", step_idx, mstep + 1);
    bo_raw = 1'b0;
    repeat (3) @(negedge clk);
    mstep = mstep + 1;
    mofs  = next_ofs(mofs, exp_ref(mstep));
    check_all("R3 after long brown-out");
  endtask

  task automatic t_ladder_wrap;
    while (mstep != 4) begin
      brownout(BLANK + 2);
      check_all("R4 ladder level");
    end
    chk("R7 ofs on at 10%", ofs_en, 1);
    bo_raw = 1'b1;
    repeat (BLANK + 1) @(negedge clk);
    chk("R8 ofs not yet off", ofs_en, 1);
    @(negedge clk);
    chk("R7 ofs off at 5% level", ofs_en, 0);
    bo_raw = 1'b0;
    repeat (3) @(negedge clk);
    mstep = 5; mofs = 1'b0;
    check_all("R4 deepest level");
    brownout(BLANK + 2);
    check_all("R5 wrap to full");
    chk("R7 ofs back on", ofs_en, 1);
  endtask

  task automatic t_supply_reset;
    brownout(BLANK + 2);
    brownout(BLANK + 2);
    check_all("R6 before supply reset");
    repeat (20) @(negedge clk);
    check_all("R3 state held while idle");
    // partial count then supply reset, then short remainder
    bo_raw = 1'b1;
    repeat (BLANK - 4) @(negedge clk);
    supply_rst = 1'b1;
    @(negedge clk);
    supply_rst = 1'b0;
    mstep = 0; mofs = 1'b1;
    chk("R6 step cleared", step_idx, 0);
    repeat (BLANK - 1) @(negedge clk);
    chk("R6 count restarted after clear", step_idx, 0);
    bo_raw = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R6 after supply reset");
    // supply reset on the same edge as an event
    bo_raw = 1'b1;
    repeat (BLANK) @(negedge clk);
    supply_rst = 1'b1;
    @(negedge clk);
    supply_rst = 1'b0;
    bo_raw = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R6 priority over event");
  endtask

  initial begin
    t_reset;
    t_short_glitch;
    t_exact_timing;
    t_ladder_wrap;
    t_supply_reset;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule